// File: doc/BRIEF.md
# Word-Boundary Deserializer with Word-Clock Generator

This block turns a source-synchronous serial stream back into 24-bit parallel words. A serial data line and its bit clock arrive on two inputs. Both are sampled by a system clock that runs at four times the bit rate. A data bit is taken on every rising edge of the sampled bit clock. The end of a word carries no sync pattern. Instead, the bit clock skips one low pulse and stays high for about three bit times. During that high stretch the data line first moves to the inverse of the last data bit and then returns to it. The block detects this condition and discards the two boundary bits. The 24 bits that came before the boundary become the received word.

The recovered word appears on the parallel port together with a word-clock pulse. The pulse falls a fixed six bit times after the boundary ends and then stays low for thirteen bit times. Between words the bit clock may keep toggling with filler bits. These filler bits never produce a pulse. A control-mode input moves two received bits to the top two output positions for links that reserve those positions for control lines. Holding the power-enable input low clears every register in the block, and the outputs then stay at zero until the first good word is decoded.

Top module: `wbd_deser`

## Requirements
- R1: Bits are taken on rising edges of the sampled serial clock. The first bit of a word appears on `par_data[0]` and the 24th on `par_data[23]`.
- R2: A word is accepted only when the serial clock has stayed high for at least HOLD_TICKS (5) system clocks and the data has meanwhile moved to the inverse of the last data bit and back. The two boundary bits never reach `par_data`.
- R3: `word_clk` falls, and `par_data` takes the new word, on the 26th system-clock edge after the first edge that sees the serial clock fall at the end of the boundary. This is six bit times plus two synchronizer stages. `par_data` changes at no other time while powered.
- R4: `word_clk` stays low for exactly 52 system clocks (13 bit times) and then returns high. It remains high until the next accepted word.
- R5: A stream with no boundary, meaning a normally toggling serial clock, produces no pulse on `word_clk` and leaves `par_data` unchanged.
- R6: While `pwr_en` is low, `par_data` is 0, `word_clk` is 1 and `frame_errs` is 0. After power-up, `par_data` stays 0 until a word is accepted.
- R7: With `ctrl2_mode` = 1 when the word is presented, received bits 21 and 22 (indices 20 and 21) drive `par_data[22]` and `par_data[23]`, and `par_data[21:20]` is 0. With `ctrl2_mode` = 0 the word is presented unchanged.
- R8: Filler bits received between a boundary and the next word are ignored. The word is always the last 24 bits before the boundary.
- R9: A boundary that ends fewer than 24 bits after the previous boundary discards the frame. No pulse is produced, and `frame_errs` increments by one, saturating at its maximum.
- R10: A long clock-high period without the inverse-then-return data toggle discards the frame and increments `frame_errs`, with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Low holds the block in power-down and clears it |
| ctrl2_mode | input | 1 | 1 selects the two-control-bit output remap |
| ser_clk | input | 1 | Received serial bit clock |
| ser_dat | input | 1 | Received serial data |
| par_data | output | WORD_BITS | Recovered parallel word |
| word_clk | output | 1 | Word clock, low pulse per accepted word |
| frame_errs | output | ERR_W | Saturating count of discarded frames |

## Verification
A wrong bit count or a bad shift direction appears on `par_data` as a rotated or reordered word. It is visible on the very next word-clock fall, 26 system clocks after the boundary ends. A corrupted high-run counter or toggle flag either drops a pulse or adds one. This shows as a missing or extra fall on `word_clk`, or as a `frame_errs` step, within one word period. A timer or state fault skews the fall time or the 52-cycle low width, and the pulse edges expose it on the first word.

// File: rtl/wbd_pkg.sv
package wbd_pkg;

   typedef enum logic [1:0] {
      WC_IDLE,
      WC_LEAD,
      WC_LOW
   } wc_state_e;

   // Minimum counter width able to hold the value n.
   function automatic int unsigned cw(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/wbd_sync.sv
module wbd_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES == 1) begin : g_one
      logic [W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stg <= '0;
         else if (clr) stg <= '0;
         else          stg <= din;
      end
      assign dout = stg;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stg <= '0;
         else if (clr) stg <= '0;
         else          stg <= {stg[STAGES-2:0], din};
      end
      assign dout = stg[STAGES-1];
   end

endmodule

// File: rtl/wbd_frame.sv
module wbd_frame
   import wbd_pkg::*;
#(
   parameter int WORD_BITS  = 24,
   parameter int HOLD_TICKS = 5,
   parameter int ERR_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 sck,
   input  logic                 sdat,
   output logic                 word_ok,
   output logic [WORD_BITS-1:0] word,
   output logic [ERR_W-1:0]     err_cnt
);

   localparam int CNT_W = cw(WORD_BITS);
   localparam int RUN_W = cw(HOLD_TICKS);

   logic                 sck_d;
   logic [WORD_BITS-1:0] shreg;
   logic [CNT_W-1:0]     bcnt;
   logic [RUN_W-1:0]     run;
   logic                 ref_b;
   logic                 saw_inv;
   logic                 saw_back;

   logic rise, fall, long_fall, frame_bad;

   assign rise      = sck & ~sck_d;
   assign fall      = ~sck & sck_d;
   assign long_fall = fall && (run >= RUN_W'(HOLD_TICKS));
   assign word_ok   = long_fall && saw_inv && saw_back && (bcnt == CNT_W'(WORD_BITS));
   assign frame_bad = long_fall && !word_ok;
   assign word      = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         shreg    <= '0;
         bcnt     <= '0;
         run      <= '0;
         ref_b    <= 1'b0;
         saw_inv  <= 1'b0;
         saw_back <= 1'b0;
         err_cnt  <= '0;
      end else if (clr) begin
         sck_d    <= 1'b0;
         shreg    <= '0;
         bcnt     <= '0;
         run      <= '0;
         ref_b    <= 1'b0;
         saw_inv  <= 1'b0;
         saw_back <= 1'b0;
         err_cnt  <= '0;
      end else begin
         sck_d <= sck;
         if (rise) begin
            // first bit received ends up in bit 0 after a full word
            shreg    <= {sdat, shreg[WORD_BITS-1:1]};
            if (bcnt != CNT_W'(WORD_BITS)) bcnt <= bcnt + 1'b1;
            run      <= RUN_W'(1);
            ref_b    <= sdat;
            saw_inv  <= 1'b0;
            saw_back <= 1'b0;
         end else begin
            if (sck) begin
               if (run != RUN_W'(HOLD_TICKS)) run <= run + 1'b1;
               if (!saw_inv && (sdat != ref_b)) saw_inv <= 1'b1;
               if (saw_inv && (sdat == ref_b))  saw_back <= 1'b1;
            end
            if (long_fall) bcnt <= '0;
         end
         if (frame_bad && (err_cnt != '1)) err_cnt <= err_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/wbd_wclk.sv
module wbd_wclk
   import wbd_pkg::*;
#(
   parameter int WORD_BITS  = 24,
   parameter int LEAD_TICKS = 24,
   parameter int LOW_TICKS  = 52
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 word_ok,
   input  logic [WORD_BITS-1:0] word,
   input  logic                 ctrl2,
   output logic [WORD_BITS-1:0] par_out,
   output logic                 wclk
);

   localparam int TMAX  = (LEAD_TICKS > LOW_TICKS) ? LEAD_TICKS : LOW_TICKS;
   localparam int TMR_W = cw(TMAX);
   localparam int CLO   = WORD_BITS - 4;

   wc_state_e            state;
   logic [TMR_W-1:0]     tmr;
   logic [WORD_BITS-1:0] hold;
   logic [WORD_BITS-1:0] mapped;

   always_comb begin
      mapped = hold;
      if (ctrl2) begin
         mapped[CLO+3 -: 2] = hold[CLO+1 -: 2];
         mapped[CLO+1 -: 2] = 2'b00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WC_IDLE;
         tmr     <= '0;
         hold    <= '0;
         par_out <= '0;
         wclk    <= 1'b1;
      end else if (clr) begin
         state   <= WC_IDLE;
         tmr     <= '0;
         hold    <= '0;
         par_out <= '0;
         wclk    <= 1'b1;
      end else if (word_ok) begin
         hold  <= word;
         state <= WC_LEAD;
         tmr   <= TMR_W'(LEAD_TICKS - 1);
         wclk  <= 1'b1;
      end else begin
         unique case (state)
            WC_LEAD: begin
               if (tmr == '0) begin
                  par_out <= mapped;
                  wclk    <= 1'b0;
                  state   <= WC_LOW;
                  tmr     <= TMR_W'(LOW_TICKS - 1);
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            WC_LOW: begin
               if (tmr == '0) begin
                  wclk  <= 1'b1;
                  state <= WC_IDLE;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            default: state <= WC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wbd_deser.sv
module wbd_deser #(
   parameter int WORD_BITS   = 24,
   parameter int OSR         = 4,
   parameter int LEAD_BITS   = 6,
   parameter int LOW_BITS    = 13,
   parameter int HOLD_TICKS  = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ERR_W       = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_en,
   input  logic                 ctrl2_mode,
   input  logic                 ser_clk,
   input  logic                 ser_dat,
   output logic [WORD_BITS-1:0] par_data,
   output logic                 word_clk,
   output logic [ERR_W-1:0]     frame_errs
);

   localparam int LEAD_TICKS = LEAD_BITS * OSR;
   localparam int LOW_TICKS  = LOW_BITS * OSR;

   if (OSR < 2) begin : g_bad_osr
      $error("OSR must be at least 2");
   end
   if (WORD_BITS < 4) begin : g_bad_word
      $error("WORD_BITS must be at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if ((HOLD_TICKS <= OSR / 2) || (HOLD_TICKS > (5 * OSR) / 2)) begin : g_bad_hold
      $error("HOLD_TICKS must lie above one high half-bit and within the boundary high time");
   end
   if ((LEAD_BITS < 1) || (LOW_BITS < 1)) begin : g_bad_pulse
      $error("word clock timing must be at least one bit time");
   end

   logic                 clr;
   logic [1:0]           sync_q;
   logic                 word_ok;
   logic [WORD_BITS-1:0] word;

   assign clr = ~pwr_en;

   wbd_sync #(
      .STAGES (SYNC_STAGES),
      .W      (2)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .din   ({ser_dat, ser_clk}),
      .dout  (sync_q)
   );

   wbd_frame #(
      .WORD_BITS  (WORD_BITS),
      .HOLD_TICKS (HOLD_TICKS),
      .ERR_W      (ERR_W)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .sck     (sync_q[0]),
      .sdat    (sync_q[1]),
      .word_ok (word_ok),
      .word    (word),
      .err_cnt (frame_errs)
   );

   wbd_wclk #(
      .WORD_BITS  (WORD_BITS),
      .LEAD_TICKS (LEAD_TICKS),
      .LOW_TICKS  (LOW_TICKS)
   ) u_wclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .word_ok (word_ok),
      .word    (word),
      .ctrl2   (ctrl2_mode),
      .par_out (par_data),
      .wclk    (word_clk)
   );

endmodule

// File: rtl/wbd_deser_chk.sv
module wbd_deser_chk #(
   parameter int WORD_BITS = 24,
   parameter int LOW_TICKS = 52,
   parameter int ERR_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pwr_en,
   input logic                 ctrl2_mode,
   input logic [WORD_BITS-1:0] par_data,
   input logic                 word_clk,
   input logic [ERR_W-1:0]     frame_errs
);

   localparam int LC_W = wbd_pkg::cw(LOW_TICKS) + 1;

   logic [LC_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_cnt <= '0;
      else if (word_clk)                   low_cnt <= '0;
      else if (low_cnt != '1)              low_cnt <= low_cnt + 1'b1;
   end

   // R4: low phase lasts exactly LOW_TICKS clocks
   a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n || !pwr_en)
      $rose(word_clk) |-> (low_cnt == LC_W'(LOW_TICKS)));

   // R6: power-down clears outputs
   a_r6_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> ((par_data == '0) && word_clk && (frame_errs == '0)));

   // R3: parallel data moves only with the word-clock fall
   a_r3_par_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && $past(pwr_en) && !$stable(par_data)) |-> $fell(word_clk));

   // R7: remapped positions are zero in control mode
   a_r7_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n || !pwr_en)
      ($fell(word_clk) && ctrl2_mode) |-> (par_data[WORD_BITS-3 -: 2] == 2'b00));

   // R9: error count only steps up by one
   a_r9_err_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en && $past(pwr_en) && !$stable(frame_errs)) |->
         (frame_errs == $past(frame_errs) + 1'b1));

endmodule

bind wbd_deser wbd_deser_chk #(
   .WORD_BITS (WORD_BITS),
   .LOW_TICKS (LOW_BITS * OSR),
   .ERR_W     (ERR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_en     (pwr_en),
   .ctrl2_mode (ctrl2_mode),
   .par_data   (par_data),
   .word_clk   (word_clk),
   .frame_errs (frame_errs)
);

// File: tb/tb_wbd_deser.sv
module tb_wbd_deser;

   localparam int NV = 7;
   localparam logic [23:0] V_IN  [NV] = '{24'hA5C396, 24'hFFFFFF, 24'h000001, 24'h800000,
                                          24'h3FFFFF, 24'h1ABCDE, 24'h555555};
   localparam logic        V_MODE[NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [23:0] V_EXP [NV] = '{24'hA5C396, 24'hFFFFFF, 24'h000001, 24'h800000,
                                          24'hCFFFFF, 24'h4ABCDE, 24'h555555};
   localparam int          V_FILL[NV] = '{0, 3, 1, 5, 2, 0, 4};

   // fall-to-word-clock delay in bench cycle units: 26 edges + the drive edge offset
   localparam int EXP_LEAD = 27;
   localparam int EXP_LOW  = 52;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, pwr_en, ctrl2, sck, sdat;
   wire [23:0] par;
   wire        wclk;
   wire [7:0]  errs;

   wbd_deser dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_en     (pwr_en),
      .ctrl2_mode (ctrl2),
      .ser_clk    (sck),
      .ser_dat    (sdat),
      .par_data   (par),
      .word_clk   (wclk),
      .frame_errs (errs)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int nfall  = 0;
   int fall_at = 0;
   int rise_at = 0;
   int drive_fall = 0;
   bit mark = 1'b0;
   logic prev_w = 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (prev_w === 1'b1 && wclk === 1'b0) begin
         nfall++;
         fall_at = cyc;
      end
      if (prev_w === 1'b0 && wclk === 1'b1) rise_at = cyc;
      prev_w = wclk;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic c, input logic d);
      @(negedge clk);
      sck  = c;
      sdat = d;
      if (mark && !c) begin
         drive_fall = cyc;
         mark = 1'b0;
      end
   endtask

   task automatic send_bit(input logic d);
      tick(1'b0, d); tick(1'b0, d); tick(1'b1, d); tick(1'b1, d);
   endtask

   task automatic send_bnd(input logic b24, input bit toggle);
      repeat (4) tick(1'b1, toggle ? ~b24 : b24);
      repeat (4) tick(1'b1, b24);
      mark = 1'b1;
   endtask

   task automatic send_bits(input logic [23:0] w, input int n);
      for (int i = 0; i < n; i++) send_bit(w[i]);
   endtask

   task automatic filler(input int n);
      for (int i = 0; i < n; i++) send_bit(logic'(i % 2));
   endtask

   task automatic settle;
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n0, e0;
      logic [23:0] p0;
      rst_n = 1'b0; pwr_en = 1'b1; ctrl2 = 1'b0; sck = 1'b0; sdat = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle;
      chk("R6 reset par", par, 0);
      chk("R6 reset wclk", wclk, 1);
      chk("R6 reset errs", errs, 0);

      // R5/R6: toggling clock without boundary
      filler(40);
      settle;
      chk("R5 no pulse", nfall, 0);
      chk("R6 par held low", par, 0);

      // table walk: R1 R2 R3 R4 R7 R8
      for (int v = 0; v < NV; v++) begin
         ctrl2 = V_MODE[v];
         filler(V_FILL[v]);
         n0 = nfall;
         send_bits(V_IN[v], 24);
         send_bnd(V_IN[v][23], 1'b1);
         filler(30);
         settle;
         chk("R2 one pulse", nfall, n0 + 1);
         chk("R3 lead delay", fall_at - drive_fall, EXP_LEAD);
         chk("R4 low width", rise_at - fall_at, EXP_LOW);
         chk(V_MODE[v] ? "R7 remapped word" : "R1 R8 word", par, V_EXP[v]);
      end
      ctrl2 = 1'b0;

      // R9: short frame right after a good word
      n0 = nfall; e0 = errs;
      send_bits(24'h0F0F0F, 24);
      send_bnd(1'b0, 1'b1);
      send_bits(24'h000155, 10);
      send_bnd(1'b0, 1'b1);
      filler(30);
      settle;
      chk("R9 only good word pulsed", nfall, n0 + 1);
      chk("R9 err incremented", errs, e0 + 1);
      chk("R9 word kept", par, 24'h0F0F0F);

      // R10: long high without data toggle
      n0 = nfall; e0 = errs;
      send_bits(24'h123456, 24);
      send_bnd(1'b0, 1'b0);
      filler(30);
      settle;
      chk("R10 no pulse", nfall, n0);
      chk("R10 err incremented", errs, e0 + 1);
      chk("R10 par unchanged", par, 24'h0F0F0F);

      // R5: long filler stream
      p0 = par; n0 = nfall;
      filler(40);
      settle;
      chk("R5 no pulse on filler", nfall, n0);
      chk("R5 par unchanged", par, p0);

      // R6: power-down and recovery
      @(negedge clk); pwr_en = 1'b0;
      repeat (4) tick(1'b0, 1'b0);
      settle;
      chk("R6 pd par", par, 0);
      chk("R6 pd wclk", wclk, 1);
      chk("R6 pd errs", errs, 0);
      @(negedge clk); pwr_en = 1'b1;
      filler(10);
      settle;
      chk("R6 par low after power-up", par, 0);
      n0 = nfall;
      send_bits(24'h6B2D19, 24);
      send_bnd(1'b0, 1'b1);
      filler(30);
      settle;
      chk("R6 first word after power-up", par, 24'h6B2D19);
      chk("R2 pulse after power-up", nfall, n0 + 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule